// File: doc/BRIEF.md
# Asynchronous Static Memory Functional Core

This block is a clocked functional stand-in for a 2048-word by 8-bit static memory controlled by three active-low levels: chip select, write enable and output enable. It holds bytes, returns read data, and works out from the control levels whether the shared data bus would be driven or left floating. The bus is split into three signals: a data input, a data output, and a drive flag that stands in for the three-state buffer. A standby flag reports when the chip is deselected.

A free-running clock samples every pin level into one register stage. All decisions are made on those samples, so a write, the drive flag and read data are all registered. Outputs follow the pins applied before a rising edge at the next rising edge after it, which is two edges after the pins change. A write is the span of samples in which chip select and write enable are both low. The byte and the address seen in the last sample of that span are committed to the array at the edge where the span ends.

The order of the select and write edges changes how the data output drives. A write that opens with chip select falling, either together with write enable or after it, keeps the output floating for the one sample in which write enable rises again. A write that opens with write enable falling under an already-selected chip resumes driving at once, and it returns the byte that was just written.

Top module: `sram_core_top`

## Requirements
- R1: Every address from 0 to 2047 holds its own byte. Address bits [3:0] pick the column and bits [10:4] pick the row. A byte written to an address is read back unchanged after all other addresses have been written.
- R2: The array changes only after samples in which chip select and write enable are both low. Write enable low while chip select is high stores nothing.
- R3: When the data input changes during a write, the byte stored is the one in the last sample before the write ends.
- R4: While chip select is high, standby reads 1 and the drive flag reads 0, whatever the other pins are. While chip select is low, standby reads 0.
- R5: While output enable is high, the drive flag reads 0, including during a write. The output enable level during a write does not change what is stored.
- R6: The drive flag is 1 exactly when chip select is low, output enable is low and write enable is high, except in the case of R7. When it is 1, the data output carries the byte stored at the sampled address.
- R7: A write that began with chip select falling, either in the same sample as write enable falling or after it, keeps the drive flag at 0 for the sample in which write enable rises with chip select still low. Normal driving resumes in the next sample.
- R8: A write that began with write enable falling while chip select was already low drives normally in the sample that ends it. The data output then carries the byte just written to that address.
- R9: The outputs change at the second rising clock edge after new pin levels are applied, and not at the first.
- R10: While reset is high, the drive flag reads 0 and standby reads 1.
- R11: When chip select and write enable rise in the same sample, the write is stored and the drive flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 11 | Word address; [3:0] column, [10:4] row |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, meaningful while dout_en is 1 |
| dout_en | output | 1 | 1 when the data bus would be driven |
| standby | output | 1 | 1 while deselected |

## Verification
The bench builds the core with its default sizes: 11 address bits split into a 4-bit column and a 7-bit row, and 8 data bits. At these sizes every one of the 2048 words can be written and read back against a reference array, so the full row and column decode is covered. The drive flag is checked for all eight chip select, write enable and output enable combinations. The bench also drives both write-opening orders, the joint rise of chip select and write enable, and a read issued in the same sample that ends a write.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};
endpackage

// File: rtl/sram_pin_sampler.sv
module sram_pin_sampler
  import sram_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output ctl_t              ctl_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] din_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= CTL_IDLE;
      addr_q <= '0;
      din_q  <= '0;
    end else begin
      ctl_q  <= '{cs_n: cs_n, we_n: we_n, oe_n: oe_n};
      addr_q <= addr;
      din_q  <= din;
    end
  end
endmodule

// File: rtl/sram_write_tracker.sv
module sram_write_tracker
  import sram_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_t              ctl,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              commit,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data,
  output logic              cs_led
);
  logic              overlap;
  logic              overlap_prev;
  logic              cs_n_prev;
  logic              cs_led_q;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_data;

  assign overlap = !ctl.cs_n && !ctl.we_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      overlap_prev <= 1'b0;
      cs_n_prev    <= 1'b1;
      cs_led_q     <= 1'b0;
      hold_addr    <= '0;
      hold_data    <= '0;
    end else begin
      overlap_prev <= overlap;
      cs_n_prev    <= ctl.cs_n;
      if (overlap) begin
        hold_addr <= addr;
        hold_data <= din;
        if (!overlap_prev) cs_led_q <= cs_n_prev;
      end
    end
  end

  assign commit      = overlap_prev && !overlap;
  assign commit_addr = hold_addr;
  assign commit_data = hold_data;
  assign cs_led      = cs_led_q;

  // R2: a commit follows a sample that was inside a write
  a_r2_commit_after_overlap: assert property (@(posedge clk) disable iff (rst)
    commit |-> $past(!ctl.cs_n && !ctl.we_n));
endmodule

// File: rtl/sram_drive_ctl.sv
module sram_drive_ctl
  import sram_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  ctl_t ctl,
  input  logic write_end,
  input  logic cs_led,
  output logic drive_q,
  output logic standby_q
);
  logic blank;
  logic drive_d;

  assign blank   = write_end && cs_led && !ctl.cs_n;
  assign drive_d = !ctl.cs_n && !ctl.oe_n && ctl.we_n && !blank;

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q   <= 1'b0;
      standby_q <= 1'b1;
    end else begin
      drive_q   <= drive_d;
      standby_q <= ctl.cs_n;
    end
  end

  // R7: a write opened by chip select floats the sample that ends it
  a_r7_cs_led_blank: assert property (@(posedge clk) disable iff (rst)
    (write_end && cs_led && !ctl.cs_n) |=> !drive_q);
  // R10: reset holds the bus floating and the chip in standby
  a_r10_reset_quiet: assert property (@(posedge clk)
    rst |=> (!drive_q && standby_q));
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ROW_W  = 7,
  parameter int COL_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ROW_W-1:0]  wrow,
  input  logic [COL_W-1:0]  wcol,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ROW_W-1:0]  rrow,
  input  logic [COL_W-1:0]  rcol,
  output logic [DATA_W-1:0] rdata
);
  localparam int IDX_W = ROW_W + COL_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  widx;
  logic [IDX_W-1:0]  ridx;

  assign widx = {wrow, wcol};
  assign ridx = {rrow, rcol};

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (we && (widx == ridx)) rdata <= wdata;
    else                      rdata <= mem[ridx];
  end
endmodule

// File: rtl/sram_core_top.sv
module sram_core_top
  import sram_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int COL_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              standby
);
  localparam int ROW_W = ADDR_W - COL_W;

  ctl_t              s_ctl;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_din;
  logic              commit;
  logic [ADDR_W-1:0] c_addr;
  logic [DATA_W-1:0] c_data;
  logic              cs_led;

  sram_pin_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_smp (
    .clk(clk), .rst(rst), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .ctl_q(s_ctl), .addr_q(s_addr), .din_q(s_din)
  );

  sram_write_tracker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wtr (
    .clk(clk), .rst(rst), .ctl(s_ctl), .addr(s_addr), .din(s_din),
    .commit(commit), .commit_addr(c_addr), .commit_data(c_data),
    .cs_led(cs_led)
  );

  sram_drive_ctl u_drv (
    .clk(clk), .rst(rst), .ctl(s_ctl), .write_end(commit),
    .cs_led(cs_led), .drive_q(dout_en), .standby_q(standby)
  );

  sram_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .we(commit),
    .wrow(c_addr[ADDR_W-1:COL_W]), .wcol(c_addr[COL_W-1:0]), .wdata(c_data),
    .rrow(s_addr[ADDR_W-1:COL_W]), .rcol(s_addr[COL_W-1:0]), .rdata(dout)
  );

  // R4: deselected samples give standby and a floating bus
  a_r4_deselect_quiet: assert property (@(posedge clk) disable iff (rst)
    s_ctl.cs_n |=> (standby && !dout_en));
  // R5: output enable high keeps the bus floating
  a_r5_oe_gates_bus: assert property (@(posedge clk) disable iff (rst)
    s_ctl.oe_n |=> !dout_en);
  // R6: write enable low never drives
  a_r6_write_floats: assert property (@(posedge clk) disable iff (rst)
    !s_ctl.we_n |=> !dout_en);
endmodule

// File: tb/sram_core_top_tb_top.sv
`timescale 1ns/100ps
module sram_core_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [10:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       dout_en, standby;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] refm [2048];

  always #2.5 clk = ~clk;

  sram_core_top dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .standby(standby)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // apply pins, then wait until the outputs reflect them
  task automatic cyc(input logic c, input logic w, input logic o,
                     input int a, input int d);
    @(negedge clk);
    cs_n = c; we_n = w; oe_n = o; addr = a[10:0]; din = d[7:0];
    @(posedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input int a, input int d);
    cyc(0, 0, 1, a, d);
    cyc(0, 1, 1, a, 0);
    refm[a] = d[7:0];
  endtask

  task automatic rd_chk(input string req, input int a);
    cyc(0, 1, 0, a, 0);
    chk(req, dout_en, 1);
    chk(req, dout, refm[a]);
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 drive", dout_en, 0);
    chk("R10 standby", standby, 1);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_fill_all;
    for (int i = 0; i < 2048; i++) wr(i, (i * 37 + (i >> 4)) & 255);
    for (int i = 0; i < 2048; i++) rd_chk("R1", i);
  endtask

  task automatic t_overlap_gate;
    cyc(1, 0, 1, 300, 8'h5A);
    cyc(1, 1, 1, 300, 0);
    cyc(0, 1, 1, 300, 8'hA5);
    rd_chk("R2", 300);
  endtask

  task automatic t_last_data;
    cyc(0, 0, 1, 77, 11);
    cyc(0, 0, 1, 77, 22);
    cyc(0, 0, 1, 77, 33);
    cyc(0, 1, 1, 77, 0);
    refm[77] = 8'd33;
    rd_chk("R3", 77);
  endtask

  task automatic t_deselect;
    cyc(1, 1, 0, 5, 0);
    chk("R4 drive", dout_en, 0);
    chk("R4 standby", standby, 1);
    cyc(1, 0, 0, 5, 0);
    chk("R4 drive", dout_en, 0);
    cyc(0, 1, 1, 5, 0);
    chk("R4 selected", standby, 0);
  endtask

  task automatic t_oe;
    cyc(0, 0, 0, 900, 8'h3C);
    chk("R5 drive in write", dout_en, 0);
    cyc(1, 1, 1, 900, 0);
    refm[900] = 8'h3C;
    cyc(0, 1, 1, 900, 0);
    chk("R5 oe high", dout_en, 0);
    rd_chk("R5", 900);
  endtask

  task automatic t_combos;
    for (int k = 0; k < 8; k++) begin
      logic c, w, o;
      c = k[2]; w = k[1]; o = k[0];
      cyc(1, 1, 1, 1500, 0);
      cyc(c, w, o, 1500, 8'hC3);
      chk("R6 drive", dout_en, (!c && !o && w) ? 1 : 0);
      chk("R4 standby", standby, c ? 1 : 0);
      if (!c && !w) refm[1500] = 8'hC3;
    end
    cyc(1, 1, 1, 1500, 0);
    rd_chk("R6", 1500);
  endtask

  task automatic t_cs_led_end;
    cyc(1, 1, 1, 200, 0);
    cyc(1, 0, 0, 200, 8'h81);
    cyc(0, 0, 0, 200, 8'h81);
    cyc(0, 1, 0, 200, 0);
    refm[200] = 8'h81;
    chk("R7 blank", dout_en, 0);
    @(posedge clk); #1;
    chk("R7 resume", dout_en, 1);
    chk("R7 data", dout, 8'h81);
    cyc(1, 1, 1, 201, 0);
    cyc(0, 0, 0, 201, 8'h42);
    cyc(0, 1, 0, 201, 0);
    refm[201] = 8'h42;
    chk("R7 joint fall blank", dout_en, 0);
    rd_chk("R7", 201);
  endtask

  task automatic t_we_led_end;
    cyc(0, 1, 1, 400, 0);
    cyc(0, 0, 0, 400, 8'hE7);
    cyc(0, 1, 0, 400, 0);
    refm[400] = 8'hE7;
    chk("R8 drive", dout_en, 1);
    chk("R8 data", dout, 8'hE7);
  endtask

  task automatic t_latency;
    cyc(1, 1, 1, 77, 0);
    @(negedge clk);
    cs_n = 0; we_n = 1; oe_n = 0; addr = 11'd77;
    @(posedge clk); #1;
    chk("R9 first edge", dout_en, 0);
    @(posedge clk); #1;
    chk("R9 second edge", dout_en, 1);
    chk("R9 data", dout, refm[77]);
  endtask

  task automatic t_joint_rise;
    cyc(0, 0, 1, 1023, 8'h99);
    cyc(1, 1, 0, 1023, 0);
    refm[1023] = 8'h99;
    chk("R11 drive", dout_en, 0);
    chk("R11 standby", standby, 1);
    rd_chk("R11", 1023);
  endtask

  bit done = 0;

  initial begin
    t_reset();
    t_fill_all();
    t_overlap_gate();
    t_last_data();
    t_deselect();
    t_oe();
    t_combos();
    t_cs_led_end();
    t_we_led_end();
    t_latency();
    t_joint_rise();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule